// File: doc/BRIEF.md
# Mode-3 Serial Frame Master

This block is a synchronous serial master that shifts words out of a small transmit queue. The serial clock idles high. Data changes on falling clock edges and is sampled on rising clock edges. While no transfer runs, the block holds the clock and the active-low select line high and releases the data-out driver. A host pushes words into the transmit queue. While the block is enabled, it frames those words on the line and gathers what it samples from the data-in pin into a receive queue, which the host pops.

A frame opens when select goes low. Half a serial-clock period later the first bit is driven and the clock makes its first, falling, edge. Words that are already queued follow back to back with select held low. Select is released one full serial-clock period after the last rising edge of the last word. The word length runs from 4 to 16 bits and is sent most significant bit first. An integer divider sets the clock half-period in system clocks.

Top module: `spi3_master`

## Requirements
- R1: Outside a frame (`ssel_n` high), `sclk` is high and does not toggle, and `mosi_oe` is low.
- R2: A frame starts only when `enable` is high, the transmit queue is not empty and the receive queue is not full. At the start `ssel_n` goes low and `mosi_oe` goes high in the same cycle, and `mosi_oe` stays high for as long as `ssel_n` is low.
- R3: The first falling `sclk` edge of a frame comes exactly D system clocks after `ssel_n` falls. D is `half_div`, and a value of 0 counts as 1. Every `sclk` high or low phase inside a frame lasts D clocks.
- R4: Within a frame, `mosi` changes only together with a falling `sclk` edge. `miso` is sampled on rising `sclk` edges.
- R5: Each word carries N bits, most significant bit first. N is `word_len`, clamped into the range 4..16 (for example, 3 gives 4 bits), and it is taken when a frame starts.
- R6: `ssel_n` rises exactly 2·D system clocks after the last rising `sclk` edge of a frame, and `sclk` is high at that moment.
- R7: Words that are queued when the current word ends go out back to back in one frame, with `ssel_n` held low between them, in push order.
- R8: Each received word is right-aligned in `rx_data` (bit 0 is the last bit sampled). A word is never pushed into a full receive queue: while that queue is full, no new word or frame starts.
- R9: `busy` is high exactly while `ssel_n` is low.
- R10: While `enable` is low, no frame starts, and queued words wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows new frames to start |
| word_len | input | LEN_W | Bits per word, clamped to 4..DATA_W |
| half_div | input | DIV_W | System clocks per serial-clock half-period (0 counts as 1) |
| tx_push | input | 1 | Write `tx_data` into the transmit queue |
| tx_data | input | DATA_W | Word to send, right-aligned |
| tx_full | output | 1 | Transmit queue full |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_data | output | DATA_W | Head of the receive queue, right-aligned |
| rx_empty | output | 1 | Receive queue empty |
| sclk | output | 1 | Serial clock, idles high |
| ssel_n | output | 1 | Active-low select |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for `mosi` (low means high impedance) |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Frame in progress |

## Verification
The assertions check the line relations on every cycle: the idle levels, the output enable following select, the data line holding still on rising clock edges, the clock being high at release, busy mirroring select, a start never coming without enable, and no push into a full receive queue. The cycle-exact lead and tail delays, bit order, word clamping, back-to-back framing and right-aligned received data depend on counts and values across a whole frame. The bench's scenarios show these by sweeping every word length against several dividers, with `miso` looped back from `mosi`, inverted in half of the runs.

// File: rtl/spi3_pkg.sv
package spi3_pkg;
  localparam int MIN_BITS = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TAIL  = 2'd3
  } spi3_state_t;
endpackage

// File: rtl/spi3_fifo.sv
module spi3_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_ptr, rd_ptr;
  logic         do_push, do_pop;

  assign empty   = (wr_ptr == rd_ptr);
  assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr[AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/spi3_engine.sv
module spi3_engine
  import spi3_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [LEN_W-1:0]  word_len,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] tx_rdata,
  output logic              tx_pop,
  input  logic              rx_full,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_wdata,
  input  logic              miso,
  output logic              sclk,
  output logic              ssel_n,
  output logic              mosi,
  output logic              mosi_oe,
  output logic              busy
);
  spi3_state_t       state;
  logic [DIV_W-1:0]  div_eff, cnt;
  logic              tick, can_go;
  logic [LEN_W-1:0]  len_new, len_q, len_use, shamt, bits_left;
  logic [DATA_W-1:0] sh_tx, sh_rx, load_word;
  logic              word_end, rise_now, last_rise;

  assign div_eff = (half_div == '0) ? DIV_W'(1) : half_div;
  assign tick    = (cnt == div_eff - 1'b1);
  assign can_go  = enable && !tx_empty && !rx_full;

  always_comb begin
    if (word_len < LEN_W'(MIN_BITS))      len_new = LEN_W'(MIN_BITS);
    else if (word_len > LEN_W'(DATA_W))   len_new = LEN_W'(DATA_W);
    else                                  len_new = word_len;
  end

  assign len_use   = (state == ST_IDLE) ? len_new : len_q;
  assign shamt     = LEN_W'(DATA_W) - len_use;
  assign load_word = tx_rdata << shamt;

  assign word_end  = (state == ST_SHIFT) && sclk && tick && (bits_left == '0);
  assign rise_now  = (state == ST_SHIFT) && !sclk && tick;
  assign last_rise = rise_now && (bits_left == LEN_W'(1));

  assign tx_pop   = ((state == ST_IDLE) && can_go) || (word_end && can_go);
  assign rx_push  = last_rise;
  assign rx_wdata = {sh_rx[DATA_W-2:0], miso};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      sclk      <= 1'b1;
      ssel_n    <= 1'b1;
      mosi      <= 1'b0;
      mosi_oe   <= 1'b0;
      busy      <= 1'b0;
      len_q     <= LEN_W'(MIN_BITS);
      bits_left <= '0;
      sh_tx     <= '0;
      sh_rx     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (can_go) begin
            state   <= ST_LEAD;
            ssel_n  <= 1'b0;
            busy    <= 1'b1;
            mosi_oe <= 1'b1;
            len_q   <= len_new;
            sh_tx   <= load_word;
            sh_rx   <= '0;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            cnt       <= '0;
            sclk      <= 1'b0;
            mosi      <= sh_tx[DATA_W-1];
            bits_left <= len_q;
            state     <= ST_SHIFT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            cnt <= '0;
            if (!sclk) begin
              sclk      <= 1'b1;
              sh_rx     <= {sh_rx[DATA_W-2:0], miso};
              bits_left <= bits_left - 1'b1;
            end else if (bits_left != '0) begin
              sclk  <= 1'b0;
              mosi  <= sh_tx[DATA_W-2];
              sh_tx <= sh_tx << 1;
            end else if (can_go) begin
              sclk      <= 1'b0;
              mosi      <= load_word[DATA_W-1];
              sh_tx     <= load_word;
              sh_rx     <= '0;
              bits_left <= len_q;
            end else begin
              state <= ST_TAIL;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TAIL: begin
          if (tick) begin
            cnt     <= '0;
            ssel_n  <= 1'b1;
            busy    <= 1'b0;
            mosi_oe <= 1'b0;
            mosi    <= 1'b0;
            state   <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi3_master.sv
module spi3_master #(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int DIV_W      = 8,
  localparam int LEN_W     = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [LEN_W-1:0]  word_len,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_full,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_empty,
  output logic              sclk,
  output logic              ssel_n,
  output logic              mosi,
  output logic              mosi_oe,
  input  logic              miso,
  output logic              busy
);
  logic              tx_empty_w, tx_pop_w;
  logic [DATA_W-1:0] tx_rdata_w, rx_wdata_w;
  logic              rx_push_w, rx_full_w;

  spi3_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst),
    .push(tx_push), .wdata(tx_data),
    .pop(tx_pop_w), .rdata(tx_rdata_w),
    .empty(tx_empty_w), .full(tx_full)
  );

  spi3_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W), .LEN_W(LEN_W)) u_eng (
    .clk(clk), .rst(rst), .enable(enable),
    .word_len(word_len), .half_div(half_div),
    .tx_empty(tx_empty_w), .tx_rdata(tx_rdata_w), .tx_pop(tx_pop_w),
    .rx_full(rx_full_w), .rx_push(rx_push_w), .rx_wdata(rx_wdata_w),
    .miso(miso), .sclk(sclk), .ssel_n(ssel_n),
    .mosi(mosi), .mosi_oe(mosi_oe), .busy(busy)
  );

  spi3_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst),
    .push(rx_push_w), .wdata(rx_wdata_w),
    .pop(rx_pop), .rdata(rx_data),
    .empty(rx_empty), .full(rx_full_w)
  );
endmodule

// File: rtl/spi3_master_chk.sv
module spi3_master_chk (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic sclk,
  input logic ssel_n,
  input logic mosi,
  input logic mosi_oe,
  input logic busy,
  input logic rx_push,
  input logic rx_full
);
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
    ssel_n |-> (sclk && !mosi_oe)); // R1
  AST_IDLE_CLK_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ssel_n && $past(ssel_n)) |-> $stable(sclk)); // R1
  AST_OE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    !ssel_n |-> mosi_oe); // R2
  AST_START_ENABLED: assert property (@(posedge clk) disable iff (rst)
    $fell(ssel_n) |-> $past(enable)); // R10
  AST_MOSI_HOLD_RISE: assert property (@(posedge clk) disable iff (rst)
    (!ssel_n && $rose(sclk)) |-> $stable(mosi)); // R4
  AST_RELEASE_CLK_HIGH: assert property (@(posedge clk) disable iff (rst)
    $rose(ssel_n) |-> sclk); // R6
  AST_BUSY_SEL: assert property (@(posedge clk) disable iff (rst)
    busy == !ssel_n); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> !rx_full); // R8
endmodule

bind spi3_master spi3_master_chk u_chk (
  .clk(clk), .rst(rst), .enable(enable),
  .sclk(sclk), .ssel_n(ssel_n), .mosi(mosi), .mosi_oe(mosi_oe),
  .busy(busy), .rx_push(rx_push_w), .rx_full(rx_full_w)
);

// File: tb/spi3_master_test.sv
`timescale 1ns/1ps
module spi3_master_test;
  localparam int DW = 16;
  localparam int LW = 5;
  localparam int VW = 4;

  logic clk = 1'b0, rst = 1'b1, enable = 1'b0;
  logic [LW-1:0] word_len = 5'd8;
  logic [VW-1:0] half_div = 4'd1;
  logic tx_push = 1'b0, rx_pop = 1'b0, inv = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic tx_full, rx_empty, sclk, ssel_n, mosi, mosi_oe, busy, miso;
  logic [DW-1:0] rx_data;

  assign miso = mosi ^ inv;
  always #2.5 clk = ~clk;

  spi3_master #(.DATA_W(DW), .FIFO_DEPTH(4), .DIV_W(VW)) uut (
    .clk(clk), .rst(rst), .enable(enable), .word_len(word_len), .half_div(half_div),
    .tx_push(tx_push), .tx_data(tx_data), .tx_full(tx_full),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty),
    .sclk(sclk), .ssel_n(ssel_n), .mosi(mosi), .mosi_oe(mosi_oe),
    .miso(miso), .busy(busy)
  );

  int checks = 0, fails = 0, cyc = 0;
  int cur_len = 8, cur_div = 1;
  int t_sel = 0, t_rise = 0, nbits = 0, ncap = 0, sel_falls = 0;
  int r4_viol = 0, r9_viol = 0;
  bit first_pend = 0, done = 0;
  logic [DW-1:0] cap = '0;
  logic [DW-1:0] cap_words [8];
  logic prev_sclk = 1'b1, prev_ssel = 1'b1, prev_mosi = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mask_of(input int n);
    return DW'((32'd1 << n) - 1);
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (busy != !ssel_n) r9_viol++;
      if (!ssel_n && !prev_ssel && (mosi != prev_mosi) && !(prev_sclk && !sclk)) r4_viol++;
      if (prev_ssel && !ssel_n) begin
        t_sel = cyc; first_pend = 1; sel_falls++;
        chk(mosi_oe == 1'b1, "R2 oe at start", int'(mosi_oe), 1);
      end
      if (prev_sclk && !sclk && first_pend) begin
        first_pend = 0;
        chk(cyc - t_sel == cur_div, "R3 lead delay", cyc - t_sel, cur_div);
      end
      if (!prev_sclk && sclk && !ssel_n) begin
        cap = {cap[DW-2:0], mosi}; nbits++; t_rise = cyc;
        if (nbits == cur_len) begin
          if (ncap < 8) cap_words[ncap] = cap;
          ncap++; nbits = 0; cap = '0;
        end
      end
      if (!prev_ssel && ssel_n)
        chk(cyc - t_rise == 2 * cur_div, "R6 tail delay", cyc - t_rise, 2 * cur_div);
    end
    prev_sclk = sclk; prev_ssel = ssel_n; prev_mosi = mosi;
  end

  task automatic push_word(input logic [DW-1:0] w);
    @(negedge clk); tx_data = w; tx_push = 1'b1;
    @(negedge clk); tx_push = 1'b0;
  endtask

  task automatic pop_check(input logic [DW-1:0] exp, input string req);
    @(negedge clk);
    chk(!rx_empty, req, int'(rx_empty), 0);
    chk(rx_data == exp, req, int'(rx_data), int'(exp));
    rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
  endtask

  task automatic wait_frame();
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic setup(input int len_set, input int len_eff, input int div_set, input logic iv);
    word_len = LW'(len_set); half_div = VW'(div_set); inv = iv;
    cur_len = len_eff; cur_div = (div_set == 0) ? 1 : div_set;
    ncap = 0; nbits = 0; cap = '0;
  endtask

  task automatic run_single(input int len_set, input int len_eff, input int div_set,
                            input logic iv, input logic [DW-1:0] w);
    logic [DW-1:0] m;
    m = mask_of(len_eff);
    setup(len_set, len_eff, div_set, iv);
    push_word(w);
    wait_frame();
    chk(ncap == 1, "R5 word count", ncap, 1);
    chk(cap_words[0] == (w & m), "R5 msb-first bits", int'(cap_words[0]), int'(w & m));
    pop_check((w ^ (iv ? m : '0)) & m, "R8 rx right-aligned");
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sclk == 1'b1, "R1 idle sclk", int'(sclk), 1);
    chk(ssel_n == 1'b1, "R1 idle ssel_n", int'(ssel_n), 1);
    chk(mosi_oe == 1'b0, "R1 idle oe", int'(mosi_oe), 0);
    chk(busy == 1'b0, "R9 idle busy", int'(busy), 0);
    chk(rx_empty == 1'b1, "R8 rx empty", int'(rx_empty), 1);

    // R10: disabled block holds queued word
    setup(8, 8, 1, 1'b0);
    push_word(16'h00A5);
    repeat (30) @(negedge clk);
    chk(busy == 1'b0 && ssel_n == 1'b1, "R10 no start while disabled", int'(busy), 0);
    enable = 1'b1;
    wait_frame();
    chk(cap_words[0] == 16'h00A5, "R10 sent after enable", int'(cap_words[0]), 16'hA5);
    pop_check(16'h00A5, "R8 rx after enable");

    // R5 R3 R6: sweep of word lengths and dividers
    for (int len = 4; len <= 16; len++)
      for (int dv = 1; dv <= 3; dv++)
        run_single(len, len, dv, logic'((len + dv) & 1), DW'(len * 4973 + dv * 911 + 16'h8001));

    // R3: divider 0 counts as 1; R5: length clamp
    run_single(12, 12, 0, 1'b0, 16'h0ABC);
    run_single(3, 4, 2, 1'b1, 16'hFFF9);
    run_single(20, 16, 1, 1'b0, 16'hC3A5);

    // R7: back-to-back frame of three words
    enable = 1'b0;
    setup(6, 6, 2, 1'b1);
    push_word(16'h002D); push_word(16'h0013); push_word(16'h003E);
    sel_falls = 0;
    enable = 1'b1;
    wait_frame();
    chk(sel_falls == 1, "R7 single select window", sel_falls, 1);
    chk(ncap == 3, "R7 words in frame", ncap, 3);
    chk(cap_words[0] == 16'h002D, "R7 order 0", int'(cap_words[0]), 16'h2D);
    chk(cap_words[1] == 16'h0013, "R7 order 1", int'(cap_words[1]), 16'h13);
    chk(cap_words[2] == 16'h003E, "R7 order 2", int'(cap_words[2]), 16'h3E);
    pop_check(16'h002D ^ 16'h003F, "R8 rx b2b 0");
    pop_check(16'h0013 ^ 16'h003F, "R8 rx b2b 1");
    pop_check(16'h003E ^ 16'h003F, "R8 rx b2b 2");

    // R8: receive queue full stalls the next word
    enable = 1'b0;
    setup(8, 8, 1, 1'b0);
    for (int i = 0; i < 4; i++) push_word(DW'(16'h0011 * (i + 1)));
    enable = 1'b1;
    wait_frame();
    chk(ncap == 4, "R8 four words sent", ncap, 4);
    push_word(16'h0099);
    repeat (40) @(negedge clk);
    chk(busy == 1'b0 && ssel_n == 1'b1, "R8 stall while rx full", int'(busy), 0);
    pop_check(16'h0011, "R8 rx full head");
    wait_frame();
    chk(ncap == 5, "R8 stalled word sent", ncap, 5);
    chk(cap_words[4] == 16'h0099, "R8 stalled word value", int'(cap_words[4]), 16'h99);
    for (int i = 1; i < 4; i++) pop_check(DW'(16'h0011 * (i + 1)), "R8 rx drain");
    pop_check(16'h0099, "R8 rx last");

    chk(r4_viol == 0, "R4 mosi only on falling sclk", r4_viol, 0);
    chk(r9_viol == 0, "R9 busy tracks select", r9_viol, 0);
    chk(sclk == 1'b1 && mosi_oe == 1'b0, "R1 idle after traffic", int'(mosi_oe), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule